// File: doc/BRIEF.md
# Stipple and Blit Raster Engine

This block performs raster operations on a byte-per-pixel frame buffer held in an internal single-port RAM. Pixels are addressed linearly, and a display line is 1024 pixels long. Software drives the engine with pairs of 32-bit word writes. A write to an even word loads a staging colour. A write to an odd word starts an operation at the pixel that the word address names. A select input chooses the kind of operation. A stipple paints the staging colour through a 32-bit mask. A blit either fills a run with the staging colour or copies a run from another pixel address.

The engine handles one pixel per clock; a copy needs two clocks per pixel, a read and then a write. While an operation runs, `busy` is high. A second start that arrives during that time is dropped, and a sticky flag records the overrun. A separate CPU pixel port gives direct byte access to the frame buffer, and it is held off whenever the engine owns the RAM.

Top module: `raster_engine`

## Requirements
- R1: After reset, `busy` and `overrun` are 0 and `pix_ready` is 1.
- R2: A write with `bus_word[0]`=0 only loads the staging colour from `bus_wdata[7:0]`. It leaves the frame buffer and `busy` unchanged.
- R3: A write with `bus_word[0]`=1 while idle starts an operation whose destination pixel is `bus_word[PIX_AW:1]` (byte address shifted right by 3). `busy` is high from the next clock until the operation ends.
- R4: Stipple (`op_sel`=0): mask bit 31 maps to destination+0 and bit 0 maps to destination+31. A set bit writes the colour and a clear bit leaves the pixel as it was. `busy` lasts exactly 32 cycles.
- R5: Blit (`op_sel`=1): the run length is `bus_wdata[28:24]`+1 (1 to 32) and the source is `bus_wdata[23:0]`. A source of 24'hFFFFFF fills the run with the colour, and `busy` then lasts one cycle per pixel. Bits 31:29 are ignored.
- R6: Any other source copies the run pixel by pixel in ascending order, reading before each write, so overlapping runs follow that order. `busy` lasts two cycles per pixel.
- R7: Destination and source pixel addresses, and their offsets, wrap modulo the RAM depth (2^PIX_AW).
- R8: A start write while `busy` is high is dropped and sets `overrun`, which stays set until reset.
- R9: The colour is captured when an operation starts. A staging write during `busy` affects only later operations.
- R10: `bus_rdata` always reads as 0.
- R11: The pixel port accepts a request only when `pix_ready` (= not busy) is high. Read data appears on `pix_rdata` with `pix_rvalid` one cycle after acceptance.
- R12: `op_sel` is sampled with the start write and selects stipple (0) or blit (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Word write strobe |
| bus_word | input | PIX_AW+1 | Word address; bit 0 selects staging (0) or start (1) |
| bus_wdata | input | 32 | Write data |
| op_sel | input | 1 | 0 = stipple, 1 = blit |
| bus_rdata | output | 32 | Read data, always 0 |
| busy | output | 1 | Operation in progress |
| overrun | output | 1 | Sticky dropped-start flag |
| pix_req | input | 1 | Pixel port request |
| pix_we | input | 1 | Pixel port write (1) or read (0) |
| pix_addr | input | PIX_AW | Pixel port address |
| pix_wdata | input | 8 | Pixel port write data |
| pix_ready | output | 1 | Pixel port may be accepted this cycle |
| pix_rvalid | output | 1 | Pixel read data valid |
| pix_rdata | output | 8 | Pixel read data |

## Verification
The embedded assertions check the following on every cycle:
- a start is followed by `busy`;
- the overrun flag rises on a dropped start and never falls;
- a copy read is always followed by its write;
- the run counter stays within the run length;
- the engine never touches the RAM while idle;
- a stalled pixel request produces no read data.

Other behaviour can only be shown by the bench's scenarios, which compare frame-buffer contents against an arithmetic model. These cover:
- the mask-to-pixel ordering;
- the smearing of an overlapping ascending copy;
- address wrap;
- colour capture while a staging write lands mid-operation;
- the exact `busy` lengths.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned PIX_W   = 8;
  localparam int unsigned RUN_W   = 5;
  localparam logic [23:0] FILL_SRC = 24'hFFFFFF;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_STIP,
    SQ_FILL,
    SQ_CRD,
    SQ_CWR
  } seq_state_e;

  typedef struct packed {
    logic              is_blit;
    logic [PIX_W-1:0]  color;
    logic [WORD_W-1:0] data;
  } cmd_t;

endpackage

// File: rtl/raster_ram.sv
module raster_ram #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Synchronous single port: a write does not update q
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) begin
        mem[addr] <= wdata;
      end else begin
        q <= mem[addr];
      end
    end
  end
endmodule

// File: rtl/raster_decode.sv
module raster_decode
  import raster_pkg::*;
#(
  parameter int unsigned PIX_AW = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [PIX_AW:0]     bus_word,
  input  logic [WORD_W-1:0]   bus_wdata,
  input  logic                op_sel,
  input  logic                busy,
  output logic                trig,
  output cmd_t                cmd,
  output logic [PIX_AW-1:0]   trig_dest,
  output logic                overrun
);
  logic [PIX_W-1:0] stage_q, stage_d;
  logic             stage_en;
  logic             start_wr;
  logic             ovr_q, ovr_d;

  assign start_wr = bus_wr & bus_word[0];
  assign stage_en = bus_wr & ~bus_word[0];
  assign stage_d  = bus_wdata[PIX_W-1:0];
  assign trig     = start_wr & ~busy;
  assign ovr_d    = ovr_q | (start_wr & busy);

  assign trig_dest   = bus_word[PIX_AW:1];
  assign cmd.is_blit = op_sel;
  assign cmd.color   = stage_q;
  assign cmd.data    = bus_wdata;
  assign overrun     = ovr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else begin
      ovr_q <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else if (stage_en) begin
      stage_q <= stage_d;
    end
  end

  AST_OVR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_word[0] && busy) |=> overrun); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R8
endmodule

// File: rtl/raster_seq.sv
module raster_seq
  import raster_pkg::*;
#(
  parameter int unsigned PIX_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  cmd_t              cmd,
  input  logic [PIX_AW-1:0] trig_dest,
  input  logic [PIX_W-1:0]  ram_q,
  output logic              busy,
  output logic              eng_en,
  output logic              eng_we,
  output logic [PIX_AW-1:0] eng_addr,
  output logic [PIX_W-1:0]  eng_wdata
);
  localparam logic [RUN_W-1:0] STIP_LAST = RUN_W'(WORD_W - 1);

  seq_state_e        state_q, state_d;
  logic [RUN_W-1:0]  cnt_q, cnt_d, last_q, last_d;
  logic [PIX_AW-1:0] dest_q, dest_d, src_q, src_d;
  logic [WORD_W-1:0] mask_q, mask_d;
  logic [PIX_W-1:0]  color_q, color_d;
  logic              at_last;
  logic              ctl_en;

  assign busy    = (state_q != SQ_IDLE);
  assign at_last = (cnt_q == last_q);
  assign ctl_en  = trig | busy;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    last_d    = last_q;
    dest_d    = dest_q;
    src_d     = src_q;
    mask_d    = mask_q;
    color_d   = color_q;
    eng_en    = 1'b0;
    eng_we    = 1'b0;
    eng_addr  = dest_q + PIX_AW'(cnt_q);
    eng_wdata = color_q;
    unique case (state_q)
      SQ_IDLE: begin
        if (trig) begin
          dest_d  = trig_dest;
          src_d   = cmd.data[PIX_AW-1:0];
          mask_d  = cmd.data;
          color_d = cmd.color;
          cnt_d   = '0;
          if (!cmd.is_blit) begin
            last_d  = STIP_LAST;
            state_d = SQ_STIP;
          end else begin
            last_d  = cmd.data[28:24];
            state_d = (cmd.data[23:0] == FILL_SRC) ? SQ_FILL : SQ_CRD;
          end
        end
      end
      SQ_STIP: begin
        eng_en = mask_q[WORD_W-1];
        eng_we = 1'b1;
        mask_d = {mask_q[WORD_W-2:0], 1'b0};
        cnt_d  = cnt_q + 1'b1;
        if (at_last) state_d = SQ_IDLE;
      end
      SQ_FILL: begin
        eng_en = 1'b1;
        eng_we = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (at_last) state_d = SQ_IDLE;
      end
      SQ_CRD: begin
        eng_en   = 1'b1;
        eng_addr = src_q + PIX_AW'(cnt_q);
        state_d  = SQ_CWR;
      end
      SQ_CWR: begin
        eng_en    = 1'b1;
        eng_we    = 1'b1;
        eng_wdata = ram_q;
        if (at_last) begin
          state_d = SQ_IDLE;
        end else begin
          cnt_d   = cnt_q + 1'b1;
          state_d = SQ_CRD;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      cnt_q   <= '0;
      last_q  <= '0;
    end else if (ctl_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      last_q  <= last_d;
    end
  end

  // Datapath registers carry no reset; loaded or stepped under ctl_en
  always_ff @(posedge clk) begin
    if (ctl_en) begin
      dest_q  <= dest_d;
      src_q   <= src_d;
      mask_q  <= mask_d;
      color_q <= color_d;
    end
  end

  AST_TRIG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> busy); // R3
  AST_STIP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_STIP) |-> (last_q == STIP_LAST)); // R4
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= last_q)); // R5
  AST_COPY_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_CRD) |=> (state_q == SQ_CWR)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !eng_en); // R11
endmodule

// File: rtl/raster_port_mux.sv
module raster_port_mux
  import raster_pkg::*;
#(
  parameter int unsigned PIX_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              eng_en,
  input  logic              eng_we,
  input  logic [PIX_AW-1:0] eng_addr,
  input  logic [PIX_W-1:0]  eng_wdata,
  input  logic              pix_req,
  input  logic              pix_we,
  input  logic [PIX_AW-1:0] pix_addr,
  input  logic [PIX_W-1:0]  pix_wdata,
  output logic              pix_ready,
  output logic              pix_rvalid,
  output logic              ram_en,
  output logic              ram_we,
  output logic [PIX_AW-1:0] ram_addr,
  output logic [PIX_W-1:0]  ram_wdata
);
  logic grant;
  logic rvalid_q, rvalid_d;

  assign pix_ready = ~busy;
  assign grant     = pix_req & ~busy;
  assign rvalid_d  = grant & ~pix_we;

  always_comb begin
    if (busy) begin
      ram_en    = eng_en;
      ram_we    = eng_we;
      ram_addr  = eng_addr;
      ram_wdata = eng_wdata;
    end else begin
      ram_en    = grant;
      ram_we    = pix_we;
      ram_addr  = pix_addr;
      ram_wdata = pix_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
    end
  end

  assign pix_rvalid = rvalid_q;

  AST_STALL_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_req && busy) |=> !pix_rvalid); // R11
endmodule

// File: rtl/raster_engine.sv
module raster_engine
  import raster_pkg::*;
#(
  parameter int unsigned PIX_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [PIX_AW:0]   bus_word,
  input  logic [31:0]       bus_wdata,
  input  logic              op_sel,
  output logic [31:0]       bus_rdata,
  output logic              busy,
  output logic              overrun,
  input  logic              pix_req,
  input  logic              pix_we,
  input  logic [PIX_AW-1:0] pix_addr,
  input  logic [7:0]        pix_wdata,
  output logic              pix_ready,
  output logic              pix_rvalid,
  output logic [7:0]        pix_rdata
);
  logic              trig;
  cmd_t              cmd;
  logic [PIX_AW-1:0] trig_dest;
  logic              eng_en, eng_we;
  logic [PIX_AW-1:0] eng_addr;
  logic [PIX_W-1:0]  eng_wdata;
  logic              ram_en, ram_we;
  logic [PIX_AW-1:0] ram_addr;
  logic [PIX_W-1:0]  ram_wdata, ram_q;

  assign bus_rdata = '0;
  assign pix_rdata = ram_q;

  raster_decode #(.PIX_AW(PIX_AW)) u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_word  (bus_word),
    .bus_wdata (bus_wdata),
    .op_sel    (op_sel),
    .busy      (busy),
    .trig      (trig),
    .cmd       (cmd),
    .trig_dest (trig_dest),
    .overrun   (overrun)
  );

  raster_seq #(.PIX_AW(PIX_AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .cmd       (cmd),
    .trig_dest (trig_dest),
    .ram_q     (ram_q),
    .busy      (busy),
    .eng_en    (eng_en),
    .eng_we    (eng_we),
    .eng_addr  (eng_addr),
    .eng_wdata (eng_wdata)
  );

  raster_port_mux #(.PIX_AW(PIX_AW)) u_mux (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .eng_en     (eng_en),
    .eng_we     (eng_we),
    .eng_addr   (eng_addr),
    .eng_wdata  (eng_wdata),
    .pix_req    (pix_req),
    .pix_we     (pix_we),
    .pix_addr   (pix_addr),
    .pix_wdata  (pix_wdata),
    .pix_ready  (pix_ready),
    .pix_rvalid (pix_rvalid),
    .ram_en     (ram_en),
    .ram_we     (ram_we),
    .ram_addr   (ram_addr),
    .ram_wdata  (ram_wdata)
  );

  raster_ram #(.AW(PIX_AW), .DW(PIX_W)) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .q     (ram_q)
  );
endmodule

// File: tb/tb_raster_engine.sv
`timescale 1ns/1ps
module tb_raster_engine;
  localparam int AW = 12;
  localparam int D  = 1 << AW;

  logic          clk, rst_n;
  logic          bus_wr, op_sel;
  logic [AW:0]   bus_word;
  logic [31:0]   bus_wdata, bus_rdata;
  logic          busy, overrun;
  logic          pix_req, pix_we, pix_ready, pix_rvalid;
  logic [AW-1:0] pix_addr;
  logic [7:0]    pix_wdata, pix_rdata;

  logic [7:0] model [D];
  int checks = 0;
  int errors = 0;

  raster_engine #(.PIX_AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .op_sel(op_sel), .bus_rdata(bus_rdata),
    .busy(busy), .overrun(overrun), .pix_req(pix_req), .pix_we(pix_we),
    .pix_addr(pix_addr), .pix_wdata(pix_wdata), .pix_ready(pix_ready),
    .pix_rvalid(pix_rvalid), .pix_rdata(pix_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int wrap(input longint a);
    return int'(((a % D) + D) % D);
  endfunction

  // All tasks start and end just after a falling edge
  task automatic bus_put(input int word, input logic [31:0] d, input logic sel);
    bus_word  = (AW+1)'(word);
    bus_wdata = d;
    op_sel    = sel;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic set_color(input int pix, input logic [7:0] c);
    bus_put(pix * 2, {24'hABCDEF, c}, 1'b0);
  endtask

  task automatic run_op(input int pix, input logic [31:0] d, input logic sel,
                        input int exp_busy, input string tag);
    int n;
    bus_put(pix * 2 + 1, d, sel);
    n = 0;
    while (busy && n < 200) begin
      n++;
      @(negedge clk);
    end
    chk(n == exp_busy, tag, n, exp_busy);
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    while (busy && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pix_wr(input int a, input logic [7:0] d);
    bit r;
    pix_req = 1'b1; pix_we = 1'b1; pix_addr = AW'(a); pix_wdata = d;
    forever begin
      r = pix_ready;
      @(negedge clk);
      if (r) break;
    end
    pix_req = 1'b0;
    model[a] = d;
  endtask

  task automatic pix_rd_chk(input int a, input string tag);
    bit r;
    pix_req = 1'b1; pix_we = 1'b0; pix_addr = AW'(a);
    forever begin
      r = pix_ready;
      @(negedge clk);
      if (r) break;
    end
    pix_req = 1'b0;
    chk(pix_rvalid === 1'b1 && pix_rdata === model[a], tag, pix_rdata, model[a]);
  endtask

  task automatic window_chk(input int base, input int n, input string tag);
    for (int k = -2; k < n + 2; k++) pix_rd_chk(wrap(base + k), tag);
  endtask

  task automatic full_chk(input string tag);
    for (int a = 0; a < D; a++) pix_rd_chk(a, tag);
  endtask

  task automatic m_stip(input int p, input logic [31:0] m, input logic [7:0] c);
    for (int i = 0; i < 32; i++) if (m[31-i]) model[wrap(p + i)] = c;
  endtask

  task automatic m_blit(input int p, input logic [31:0] d, input logic [7:0] c);
    int len;
    longint src;
    len = int'(d[28:24]) + 1;
    src = longint'(d[23:0]);
    for (int i = 0; i < len; i++) begin
      if (d[23:0] == 24'hFFFFFF) model[wrap(p + i)] = c;
      else model[wrap(p + i)] = model[wrap(src + i)];
    end
  endtask

  task automatic do_stip(input int p, input logic [31:0] m, input logic [7:0] c, input string tag);
    set_color(p, c);
    m_stip(p, m, c);
    run_op(p, m, 1'b0, 32, tag);
    window_chk(p, 32, tag);
  endtask

  task automatic do_blit(input int p, input logic [31:0] d, input logic [7:0] c, input string tag);
    int len;
    len = int'(d[28:24]) + 1;
    set_color(p, c);
    m_blit(p, d, c);
    run_op(p, d, 1'b1, (d[23:0] == 24'hFFFFFF) ? len : 2 * len, tag);
    window_chk(p, len, tag);
  endtask

  function automatic logic [31:0] bl(input int len, input int src, input logic [2:0] hi);
    return {hi, 5'(len - 1), 24'(src)};
  endfunction

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_word = '0; bus_wdata = '0; op_sel = 1'b0;
    pix_req = 1'b0; pix_we = 1'b0; pix_addr = '0; pix_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(overrun == 1'b0, "R1 overrun", overrun, 0);
    chk(pix_ready == 1'b1, "R1 pix_ready", pix_ready, 1);
    chk(bus_rdata == 32'h0, "R10 rdata", bus_rdata, 0);

    // R11 load the whole frame buffer through the pixel port, read back
    for (int a = 0; a < D; a++) pix_wr(a, 8'((a * 37 + 11) & 255));
    full_chk("R11 sweep");

    // R2 staging write alone changes nothing
    bus_put(900 * 2, 32'hDEAD_BE5A, 1'b1);
    chk(busy == 1'b0, "R2 busy", busy, 0);
    window_chk(900, 4, "R2 untouched");

    // R4 stipple ordering, several masks
    do_stip(100, 32'hFFFFFFFF, 8'hC1, "R4 all ones");
    do_stip(300, 32'h80000001, 8'hC2, "R4 ends");
    do_stip(520, 32'hA5A50F0F, 8'hC3, "R4 pattern");
    do_stip(700, 32'h00000000, 8'hC4, "R4 empty");
    do_stip(D - 10, 32'hF0F0F0F1, 8'hC5, "R7 stipple wrap");

    // R5 fills, upper bits ignored
    do_blit(1000, bl(1, 24'hFFFFFF, 3'b000), 8'h51, "R5 fill len1");
    do_blit(1040, bl(32, 24'hFFFFFF, 3'b111), 8'h52, "R5 fill len32");
    do_blit(1100, bl(7, 24'hFFFFFF, 3'b101), 8'h53, "R5 fill len7");
    do_blit(D - 3, bl(7, 24'hFFFFFF, 3'b010), 8'h54, "R7 fill wrap");

    // R6 copies
    do_blit(1200, bl(16, 40, 3'b000), 8'h00, "R6 copy");
    do_blit(1250, bl(1, 60, 3'b000), 8'h00, "R6 copy len1");
    do_blit(1601, bl(8, 1600, 3'b000), 8'h00, "R6 overlap up");
    do_blit(1700, bl(32, 1701, 3'b000), 8'h00, "R6 overlap down");
    do_blit(1800, bl(32, 24'h001FF0, 3'b000), 8'h00, "R7 copy src wrap");
    do_blit(1900, bl(2, 24'hFFFFFE, 3'b000), 8'h00, "R7 copy high src");

    // R12 same data, op_sel picks the operation
    do_stip(2000, 32'h03FFFFFF, 8'h61, "R12 sel stipple");
    do_blit(2100, 32'h03FFFFFF, 8'h62, "R12 sel blit");

    // R9 colour captured at start
    set_color(2200, 8'h11);
    bus_put(2200 * 2 + 1, bl(32, 24'hFFFFFF, 3'b000), 1'b1);
    bus_put(2200 * 2, 32'h0000_0022, 1'b0);
    wait_idle();
    m_blit(2200, bl(32, 24'hFFFFFF, 3'b000), 8'h11);
    window_chk(2200, 32, "R9 old colour");
    chk(overrun == 1'b0, "R8 no false overrun", overrun, 0);
    bus_put(2300 * 2 + 1, bl(4, 24'hFFFFFF, 3'b000), 1'b1);
    wait_idle();
    m_blit(2300, bl(4, 24'hFFFFFF, 3'b000), 8'h22);
    window_chk(2300, 4, "R9 new colour");

    // R8 start while busy is dropped
    set_color(2400, 8'h33);
    bus_put(2400 * 2 + 1, bl(8, 24'hFFFFFF, 3'b000), 1'b1);
    bus_put(2500 * 2 + 1, 32'hFFFFFFFF, 1'b0);
    wait_idle();
    m_blit(2400, bl(8, 24'hFFFFFF, 3'b000), 8'h33);
    chk(overrun == 1'b1, "R8 overrun set", overrun, 1);
    window_chk(2400, 8, "R8 first op");
    window_chk(2500, 32, "R8 dropped op");
    do_blit(2550, bl(3, 24'hFFFFFF, 3'b000), 8'h34, "R8 later op");
    chk(overrun == 1'b1, "R8 sticky", overrun, 1);

    // R11 pixel port stalled while busy
    set_color(2600, 8'h44);
    bus_put(2600 * 2 + 1, bl(16, 24'hFFFFFF, 3'b000), 1'b1);
    m_blit(2600, bl(16, 24'hFFFFFF, 3'b000), 8'h44);
    chk(pix_ready == 1'b0, "R11 ready low", pix_ready, 0);
    pix_wr(2601, 8'h99);
    chk(busy == 1'b0, "R11 write after idle", busy, 0);
    window_chk(2600, 16, "R11 stalled write");

    chk(bus_rdata == 32'h0, "R10 rdata after ops", bus_rdata, 0);
    full_chk("R7 final sweep");
    finish_run();
  end
endmodule